// File: doc/BRIEF.md
# Run-State and Service-Flag Controller

This block holds the operating state of a FIFO-based serial data engine, together with the sticky event flags that the engine raises when it needs service. Software moves the engine between reset, run and pause by writing a 2-bit code. It polls a valid bit to learn when the change has taken effect. Moving into pause is accepted only while the engine is running. A separate soft-reset strobe returns the engine to reset at once and clears the flags.

The data path pulses three event inputs: output needs service, input needs service, and input transfer complete. Each pulse sets a flag that stays set until software writes 1 to that flag's bit. A per-flag enable mask gates the flags onto one interrupt line. A status input from the protocol engine reports whether it is generating bus traffic as a master, and software reads it in the state word before starting each transfer.

The register port has one write channel and one combinational read channel, each selected by a 2-bit address: 0 is the state word, 1 is the soft reset, 2 is the flags and 3 is the interrupt enables.

Top module: `rsc_run_ctrl`

## Requirements
- R1: After reset the state word reads 0x0004 (state reset, valid set), the flag and enable words read 0 and `irq_o` is low.
- R2: The state word at address 0 carries the committed state in bits [1:0] (reset = 0, run = 1, pause = 3), valid in bit 2, `mgen_i` in bit 4, and zeros elsewhere; code 2 is never held.
- R3: A state write that is accepted clears valid for exactly SETTLE_CYC cycles after the write edge. During that window bits [1:0] keep the previous state. The new state and valid = 1 appear together on the next cycle.
- R4: A state write is ignored (state and valid unchanged) when it requests pause while the committed state is not run, when it carries code 2, or when it arrives while valid is low.
- R5: Writing a word with bit 0 set to address 1 puts the state at reset with valid set on the next cycle. It cancels any pending change, clears all flags and keeps the enables. Writing bit 0 = 0 there has no effect.
- R6: A one-cycle pulse on `ev_out_svc_i`, `ev_in_svc_i` or `ev_in_done_i` sets flag bit 8, 9 or 11 of address 2 respectively on the next cycle, and the flag stays set without further pulses.
- R7: Writing address 2 clears exactly the flags whose bit (8, 9, 11) is 1 in the data. If an event arrives in the same cycle as the clear of its flag, the flag stays set.
- R8: Address 3 holds one enable per flag at bits 8, 9 and 11. `irq_o` is high exactly when some flag is set together with its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |
| mgen_i | input | 1 | Protocol engine is generating bus traffic as master |
| ev_out_svc_i | input | 1 | Output service event pulse |
| ev_in_svc_i | input | 1 | Input service event pulse |
| ev_in_done_i | input | 1 | Input transfer complete pulse |
| irq_o | output | 1 | Interrupt, OR of enabled flags |

## Verification
Several cases are hard to reach from the ports because they exist only inside the short settle window. Examples are a second state write that lands while valid is low, and a soft reset that overlaps a pending change. The stimulus reaches them by issuing back-to-back writes on consecutive clock edges, straight after an accepted state request from a known starting state. Every start state is crossed with every requested code. This exercises the pause-from-run rule and the illegal code, and each flag clear mask and each enable/flag combination is also swept.

// File: rtl/rsc_pkg.sv
`timescale 1ns/1ps
package rsc_pkg;
   localparam int ADDR_W = 2;

   localparam logic [ADDR_W-1:0] A_STATE = 2'd0;
   localparam logic [ADDR_W-1:0] A_SRST  = 2'd1;
   localparam logic [ADDR_W-1:0] A_FLAGS = 2'd2;
   localparam logic [ADDR_W-1:0] A_IEN   = 2'd3;

   localparam logic [1:0] ST_RESET = 2'd0;
   localparam logic [1:0] ST_RUN   = 2'd1;
   localparam logic [1:0] ST_BAD   = 2'd2;
   localparam logic [1:0] ST_PAUSE = 2'd3;

   localparam int VALID_BIT = 2;
   localparam int MGEN_BIT  = 4;
   localparam int NUM_FLAGS = 3;
   localparam int TOP_BIT   = 11;

   // bit position of flag i within the flag and enable words
   function automatic int flag_pos(input int i);
      case (i)
         0:       return 8;
         1:       return 9;
         default: return 11;
      endcase
   endfunction
endpackage

// File: rtl/rsc_sequencer.sv
`timescale 1ns/1ps
module rsc_sequencer
   import rsc_pkg::*;
#(
   parameter int SETTLE_CYC = 2,
   localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_wr,
   input  logic [1:0] req_code,
   input  logic       sw_rst,
   output logic [1:0] state_o,
   output logic       valid_o
);
   logic [1:0]       state_q, target_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy, legal;

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("rsc_sequencer: SETTLE_CYC must be at least 1");
   end

   assign busy  = (cnt_q != '0);
   assign legal = !busy && (req_code != ST_BAD) &&
                  !((req_code == ST_PAUSE) && (state_q != ST_RUN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_RESET;
         target_q <= ST_RESET;
         cnt_q    <= '0;
      end else if (sw_rst) begin
         state_q  <= ST_RESET;
         target_q <= ST_RESET;
         cnt_q    <= '0;
      end else if (busy) begin
         cnt_q <= cnt_q - CNT_W'(1);
         if (cnt_q == CNT_W'(1)) state_q <= target_q;
      end else if (req_wr && legal) begin
         target_q <= req_code;
         cnt_q    <= CNT_W'(SETTLE_CYC);
      end
   end

   assign state_o = state_q;
   assign valid_o = !busy;
endmodule

// File: rtl/rsc_flag_bank.sv
`timescale 1ns/1ps
module rsc_flag_bank #(
   parameter int NUM_FLAGS = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_FLAGS-1:0] set_i,
   input  logic [NUM_FLAGS-1:0] clr_i,
   input  logic                 flush_i,
   output logic [NUM_FLAGS-1:0] flags_o
);
   if (NUM_FLAGS < 1) begin : g_bad_n
      $error("rsc_flag_bank: NUM_FLAGS must be at least 1");
   end

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      logic f_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         f_q <= 1'b0;
         else if (flush_i)   f_q <= 1'b0;
         else if (set_i[i])  f_q <= 1'b1;
         else if (clr_i[i])  f_q <= 1'b0;
      end
      assign flags_o[i] = f_q;
   end
endmodule

// File: rtl/rsc_irq_gen.sv
`timescale 1ns/1ps
module rsc_irq_gen #(
   parameter int NUM_FLAGS  = 3,
   parameter bit REGISTERED = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_FLAGS-1:0] flags_i,
   input  logic [NUM_FLAGS-1:0] en_i,
   output logic                 irq_o
);
   logic req;
   assign req = |(flags_i & en_i);

   if (REGISTERED) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= req;
      end
      assign irq_o = irq_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq_o = req;
   end
endmodule

// File: rtl/rsc_run_ctrl.sv
`timescale 1ns/1ps
module rsc_run_ctrl
   import rsc_pkg::*;
#(
   parameter int DATA_W         = 16,
   parameter int SETTLE_CYC     = 2,
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              mgen_i,
   input  logic              ev_out_svc_i,
   input  logic              ev_in_svc_i,
   input  logic              ev_in_done_i,
   output logic              irq_o
);
   if (DATA_W <= TOP_BIT) begin : g_bad_w
      $error("rsc_run_ctrl: DATA_W must exceed the highest flag bit");
   end

   logic                 wr_state, wr_srst, wr_flags, wr_ien;
   logic                 srst;
   logic [1:0]           state_cur;
   logic                 state_valid;
   logic [NUM_FLAGS-1:0] flag_q, ien_q, clr_vec, ev_vec;
   logic [DATA_W-1:0]    state_word, flag_word, ien_word;
   logic                 unused_wdata;

   assign unused_wdata = ^wr_data;

   assign wr_state = wr_en && (wr_addr == A_STATE);
   assign wr_srst  = wr_en && (wr_addr == A_SRST);
   assign wr_flags = wr_en && (wr_addr == A_FLAGS);
   assign wr_ien   = wr_en && (wr_addr == A_IEN);
   assign srst     = wr_srst && wr_data[0];

   assign ev_vec = {ev_in_done_i, ev_in_svc_i, ev_out_svc_i};

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_clr
      assign clr_vec[i] = wr_flags && wr_data[flag_pos(i)];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q <= '0;
      end else if (wr_ien) begin
         for (int i = 0; i < NUM_FLAGS; i++) ien_q[i] <= wr_data[flag_pos(i)];
      end
   end

   rsc_sequencer #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_wr   (wr_state),
      .req_code (wr_data[1:0]),
      .sw_rst   (srst),
      .state_o  (state_cur),
      .valid_o  (state_valid)
   );

   rsc_flag_bank #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (ev_vec),
      .clr_i   (clr_vec),
      .flush_i (srst),
      .flags_o (flag_q)
   );

   rsc_irq_gen #(.NUM_FLAGS(NUM_FLAGS), .REGISTERED(IRQ_REGISTERED)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (flag_q),
      .en_i    (ien_q),
      .irq_o   (irq_o)
   );

   always_comb begin
      state_word              = '0;
      state_word[1:0]         = state_cur;
      state_word[VALID_BIT]   = state_valid;
      state_word[MGEN_BIT]    = mgen_i;
      flag_word               = '0;
      ien_word                = '0;
      for (int i = 0; i < NUM_FLAGS; i++) begin
         flag_word[flag_pos(i)] = flag_q[i];
         ien_word[flag_pos(i)]  = ien_q[i];
      end
   end

   always_comb begin
      case (rd_addr)
         A_STATE: rd_data = state_word;
         A_FLAGS: rd_data = flag_word;
         A_IEN:   rd_data = ien_word;
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/rsc_run_ctrl_chk.sv
`timescale 1ns/1ps
module rsc_run_ctrl_chk
   import rsc_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic [1:0]           wr_addr,
   input logic [DATA_W-1:0]    wr_data,
   input logic [1:0]           state_cur,
   input logic                 state_valid,
   input logic [NUM_FLAGS-1:0] flag_q,
   input logic [NUM_FLAGS-1:0] ien_q,
   input logic                 irq_o
);
   logic unused_chk;
   assign unused_chk = ^wr_data;

   logic st_wr, legal_req, do_srst, clr0;
   assign st_wr     = wr_en && (wr_addr == A_STATE);
   assign legal_req = (wr_data[1:0] == ST_RESET) || (wr_data[1:0] == ST_RUN) ||
                      ((wr_data[1:0] == ST_PAUSE) && (state_cur == ST_RUN));
   assign do_srst   = wr_en && (wr_addr == A_SRST) && wr_data[0];
   assign clr0      = wr_en && (wr_addr == A_FLAGS) && wr_data[flag_pos(0)];

   assert_no_bad_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      state_cur != ST_BAD);

   assert_valid_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && state_valid && legal_req) |=> !state_valid);

   assert_pause_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && state_valid && (wr_data[1:0] == ST_PAUSE) && (state_cur != ST_RUN))
      |=> (state_valid && $stable(state_cur)));

   assert_soft_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      do_srst |=> (state_valid && (state_cur == ST_RESET) && (flag_q == '0)));

   assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[0] && !clr0 && !do_srst) |=> flag_q[0]);

   assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (((flag_q & ien_q) == '0) && ($past(flag_q & ien_q) == '0)) |-> !irq_o);
endmodule

bind rsc_run_ctrl rsc_run_ctrl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_rsc_run_ctrl.sv
`timescale 1ns/1ps
module tb_rsc_run_ctrl;
   localparam int SET = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        mgen_i = 1'b0;
   logic        ev_out = 1'b0, ev_in = 1'b0, ev_done = 1'b0;
   logic        irq_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   rsc_run_ctrl dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .mgen_i(mgen_i), .ev_out_svc_i(ev_out), .ev_in_svc_i(ev_in),
      .ev_in_done_i(ev_done), .irq_o(irq_o)
   );

   // flag mask -> word: bit0 at 8, bit1 at 9, bit2 at 11
   function automatic logic [15:0] fw(input int m);
      return 16'((m & 1) << 8) | 16'(((m >> 1) & 1) << 9) | 16'(((m >> 2) & 1) << 11);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic pulse(input int m);
      @(negedge clk);
      ev_out = m[0]; ev_in = m[1]; ev_done = m[2];
      @(negedge clk);
      ev_out = 1'b0; ev_in = 1'b0; ev_done = 1'b0;
   endtask

   task automatic go_state(input int s);
      wr(2'd1, 16'h0001);
      if (s != 0) begin
         wr(2'd0, 16'd1);
         repeat (SET) @(negedge clk);
         if (s == 3) begin
            wr(2'd0, 16'd3);
            repeat (SET) @(negedge clk);
         end
      end
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(2'd0, d); chk("R1 state word", d, 16'h0004);
      rd(2'd2, d); chk("R1 flags", d, 0);
      rd(2'd3, d); chk("R1 enables", d, 0);
      chk("R1 irq", irq_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(2'd0, d); chk("R1 state after release", d, 16'h0004);

      // R2 master-generating bit
      mgen_i = 1'b1; rd(2'd0, d); chk("R2 mgen bit4", d, 16'h0014);
      mgen_i = 1'b0; rd(2'd0, d); chk("R2 mgen low", d, 16'h0004);

      // R3/R4 sweep: each start state x each requested code
      for (int si = 0; si < 3; si++) begin
         for (int c = 0; c < 4; c++) begin
            int s;
            bit legal;
            s = (si == 0) ? 0 : (si == 1) ? 1 : 3;
            legal = (c == 0) || (c == 1) || ((c == 3) && (s == 1));
            go_state(s);
            rd(2'd0, d); chk("R2 start state", d, 4 | s);
            wr(2'd0, 16'(c));
            if (legal) begin
               for (int k = 0; k < SET; k++) begin
                  if (k > 0) @(negedge clk);
                  rd(2'd0, d); chk("R3 settle window", d, s);
               end
               @(negedge clk);
               rd(2'd0, d); chk("R3 committed", d, 4 | c);
            end else begin
               rd(2'd0, d); chk("R4 ignored request", d, 4 | s);
               @(negedge clk);
               rd(2'd0, d); chk("R4 ignored later", d, 4 | s);
            end
         end
      end

      // R4 write while valid low is ignored (pause would be legal from run)
      go_state(1);
      wr(2'd0, 16'd0);
      wr(2'd0, 16'd3);
      repeat (SET + 1) @(negedge clk);
      rd(2'd0, d); chk("R4 write during settle", d, 16'h0004);

      // R5 soft reset cancels pending change
      go_state(0);
      wr(2'd0, 16'd1);
      wr(2'd1, 16'h0001);
      rd(2'd0, d); chk("R5 soft reset immediate", d, 16'h0004);
      repeat (SET + 2) @(negedge clk);
      rd(2'd0, d); chk("R5 pending cancelled", d, 16'h0004);

      // R5 bit0 clear has no effect
      go_state(1);
      wr(2'd1, 16'hFFFE);
      rd(2'd0, d); chk("R5 no-op write", d, 16'h0005);

      // R6 per-flag set and stickiness
      for (int f = 0; f < 3; f++) begin
         wr(2'd1, 16'h0001);
         pulse(1 << f);
         rd(2'd2, d); chk("R6 flag set", d, fw(1 << f));
         repeat (4) @(negedge clk);
         rd(2'd2, d); chk("R6 flag sticky", d, fw(1 << f));
      end

      // R7 write-one-to-clear sweep
      for (int m = 0; m < 8; m++) begin
         wr(2'd1, 16'h0001);
         pulse(7);
         wr(2'd2, fw(m) | 16'h04FF);
         rd(2'd2, d); chk("R7 clear mask", d, fw(7 & ~m));
      end

      // R7 event beats clear in the same cycle
      wr(2'd1, 16'h0001);
      pulse(7);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = fw(7); ev_out = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; ev_out = 1'b0;
      rd(2'd2, d); chk("R7 set wins", d, fw(1));

      // R5 soft reset clears flags
      wr(2'd1, 16'h0001);
      rd(2'd2, d); chk("R5 flags cleared", d, 0);

      // R8 enables x flag patterns
      for (int en = 0; en < 8; en++) begin
         wr(2'd3, fw(en) | 16'h00FF);
         rd(2'd3, d); chk("R8 enable readback", d, fw(en));
         for (int p = 0; p < 8; p++) begin
            wr(2'd1, 16'h0001);
            chk("R8 irq idle", irq_o, 0);
            pulse(p);
            chk("R8 irq", irq_o, ((p & en) != 0) ? 1 : 0);
         end
      end

      // R5 enables survive soft reset
      wr(2'd3, fw(5));
      wr(2'd1, 16'h0001);
      rd(2'd3, d); chk("R5 enables kept", d, fw(5));

      done = 1'b1;
      summary();
      $finish;
   end
endmodule